// File: doc/BRIEF.md
# Pipeline Hazard Flush Controller

This block decides when a six-stage in-order pipeline must throw away work and refetch. The stages, oldest last, are fetch, decode, register read, execute 1, execute 2 and writeback. The block owns the per-stage valid bits. Each clock, a new valid bit enters fetch and every bit moves one stage along, with no stalls. It watches the register indices, write enables, memory-operation kinds and captured instruction addresses that the datapath presents for each stage. From these it raises a per-stage flush mask and a restart address. No hazard is resolved by forwarding or stalling. Every hazard kills the affected younger work, and fetch restarts from an address taken from the address captured for the instruction that caused it.

Three hazards are classified in one combinational step. The classification is an enumerated cause with four values:

- `CAUSE_NONE`: no hazard this cycle.
- `CAUSE_RAW`: a source register of the instruction in register read is still waiting to be written by a valid instruction further down the pipe.
- `CAUSE_JUMP`: the instruction in execute 1 resolved a taken jump or branch.
- `CAUSE_PORT`: execute 1 wants to read data memory while execute 2 is writing it, and only one data port exists.

The cause is chosen by a fixed priority, from the oldest origin to the youngest: `CAUSE_PORT`, then `CAUSE_JUMP`, then `CAUSE_RAW`, and `CAUSE_NONE` when none applies. There is no held state between cause values. The cause is re-evaluated every cycle. The registered state is the valid chain, which goes from all-clear at reset to shifting on each edge.

Top module: `pipe_flush_ctrl`

## Requirements
- R1: At reset all six stage valid bits are 0. At each clock edge, fetch's valid bit takes `fetch_req_i`, and stage s+1 takes stage s's valid bit unless stage s was flagged in `flush_o` during that cycle, in which case stage s+1 becomes 0. Bit k of `stage_valid_o` and `flush_o` is stage k: 0 fetch, 1 decode, 2 register read, 3 execute 1, 4 execute 2, 5 writeback.
- R2: A register counts as pending when a valid stage among execute 1, execute 2 and writeback has its write enable set and that register as its destination. Register index 0 is never pending.
- R3: If register read is valid and a used source index is pending, `flush_o` is 6'b000111 and the restart address is `pc_rr_i`.
- R4: If execute 1 is valid and `ex1_jump_i` is 1, `flush_o` is 6'b000111 and the restart address is `pc_ex1_i + ex1_jump_off_i`, with the sum wrapping modulo 2^XLEN.
- R5: Memory kinds are encoded as 2'b01 for a load and 2'b10 for a store; 2'b00 and 2'b11 mean no memory access. If execute 1 is valid with a load and execute 2 is valid with a store, `flush_o` is 6'b001111 and the restart address is `pc_ex1_i`.
- R6: Requests from stages whose valid bit is 0 have no effect on `flush_o` or the restart output.
- R7: When several hazards apply in the same cycle, the memory-port conflict wins over the jump, and the jump wins over the read-after-write case.
- R8: With no hazard, `flush_o` is 0, `redirect_valid_o` is 0 and `redirect_pc_o` is 0. With any hazard, `redirect_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_i | input | 1 | A new instruction enters fetch at this edge |
| stage_valid_o | output | 6 | Valid bit per stage, bit 0 fetch to bit 5 writeback |
| rs1_idx_i | input | REG_W | First source index in register read |
| rs1_used_i | input | 1 | First source is read |
| rs2_idx_i | input | REG_W | Second source index in register read |
| rs2_used_i | input | 1 | Second source is read |
| pc_rr_i | input | XLEN | Captured address of the register-read instruction |
| ex1_rd_i | input | REG_W | Destination index in execute 1 |
| ex1_wen_i | input | 1 | Execute 1 writes a register |
| ex1_mem_i | input | 2 | Memory kind in execute 1 |
| ex1_jump_i | input | 1 | Execute 1 resolved a taken jump |
| ex1_jump_off_i | input | XLEN | Jump offset relative to the execute 1 address |
| pc_ex1_i | input | XLEN | Captured address of the execute 1 instruction |
| ex2_rd_i | input | REG_W | Destination index in execute 2 |
| ex2_wen_i | input | 1 | Execute 2 writes a register |
| ex2_mem_i | input | 2 | Memory kind in execute 2 |
| wb_rd_i | input | REG_W | Destination index in writeback |
| wb_wen_i | input | 1 | Writeback writes a register |
| flush_o | output | 6 | Per-stage flush, bit 0 fetch to bit 5 writeback |
| redirect_valid_o | output | 1 | Restart address is meaningful |
| redirect_pc_o | output | XLEN | Restart address |

## Verification
The flush mask and the restart outputs are combinational in the current inputs and the valid bits. The bench drives inputs on the falling edge and samples these outputs 1 time unit later in the same cycle. The valid bits change only at the rising edge. Their expected value is advanced by a bench model at each rising edge and compared at the following falling edge, before new inputs are applied. A sweep of about twenty thousand hashed input patterns varies the register indices, enables, memory kinds, jump flag and fetch requests, so that all causes, their overlaps, index 0 and invalid stages all occur.

// File: rtl/pipe_flush_pkg.sv
package pipe_flush_pkg;

    localparam int unsigned NUM_STAGES = 6;
    localparam int unsigned NUM_PROD   = 3;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_REGRD  = 3'd2,
        ST_EXE1   = 3'd3,
        ST_EXE2   = 3'd4,
        ST_WBACK  = 3'd5
    } stage_e;

    typedef enum logic [1:0] {
        MEM_NONE  = 2'b00,
        MEM_LOAD  = 2'b01,
        MEM_STORE = 2'b10
    } mem_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_RAW  = 2'd1,
        CAUSE_JUMP = 2'd2,
        CAUSE_PORT = 2'd3
    } cause_e;

    localparam logic [NUM_STAGES-1:0] MASK_FRONT   = 6'b000111;
    localparam logic [NUM_STAGES-1:0] MASK_TO_EXE1 = 6'b001111;

endpackage

// File: rtl/pipe_valid_chain.sv
module pipe_valid_chain
    import pipe_flush_pkg::*;
#(
    parameter int unsigned N = NUM_STAGES
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         fetch_req_i,
    input  logic [N-1:0] flush_i,
    output logic [N-1:0] valid_o
);

    logic [N-1:0] valid_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= '0;
        end else begin
            valid_q <= {valid_q[N-2:0] & ~flush_i[N-2:0], fetch_req_i};
        end
    end

    assign valid_o = valid_q;

    // R1: a new fetch bit appears one edge after it is requested
    p_fetch_enters_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (valid_q[0] == $past(fetch_req_i)));

    // R1: a flushed execute-1 instruction never reaches execute 2
    p_flushed_gone_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i[ST_EXE1] |=> !valid_q[ST_EXE2]);

endmodule

// File: rtl/pipe_scoreboard.sv
module pipe_scoreboard
    import pipe_flush_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    localparam int unsigned NREG = 1 << REG_W
) (
    input  logic [NUM_PROD-1:0] prod_valid_i,
    input  logic [NUM_PROD-1:0] prod_wen_i,
    input  logic [REG_W-1:0]    prod_rd_i [NUM_PROD],
    output logic [NREG-1:0]     pending_o
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (r == 0) begin : g_zero
            assign pending_o[r] = 1'b0;
        end else begin : g_track
            always_comb begin
                pending_o[r] = 1'b0;
                for (int p = 0; p < NUM_PROD; p++) begin
                    if (prod_valid_i[p] && prod_wen_i[p] &&
                        (prod_rd_i[p] == REG_W'(r))) begin
                        pending_o[r] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pipe_hazard_arbiter.sv
module pipe_hazard_arbiter
    import pipe_flush_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned XLEN  = 32,
    localparam int unsigned NREG = 1 << REG_W
) (
    input  logic [NUM_STAGES-1:0] valid_i,
    input  logic [NREG-1:0]       pending_i,
    input  logic [REG_W-1:0]      rs1_idx_i,
    input  logic                  rs1_used_i,
    input  logic [REG_W-1:0]      rs2_idx_i,
    input  logic                  rs2_used_i,
    input  logic [XLEN-1:0]       pc_rr_i,
    input  logic                  ex1_jump_i,
    input  logic [XLEN-1:0]       ex1_jump_off_i,
    input  logic [XLEN-1:0]       pc_ex1_i,
    input  logic [1:0]            ex1_mem_i,
    input  logic [1:0]            ex2_mem_i,
    output logic [NUM_STAGES-1:0] flush_o,
    output logic                  redirect_valid_o,
    output logic [XLEN-1:0]       redirect_pc_o
);

    logic   raw_hit;
    logic   jump_hit;
    logic   port_hit;
    cause_e cause;

    assign raw_hit  = valid_i[ST_REGRD] &&
                      ((rs1_used_i && pending_i[rs1_idx_i]) ||
                       (rs2_used_i && pending_i[rs2_idx_i]));
    assign jump_hit = valid_i[ST_EXE1] && ex1_jump_i;
    assign port_hit = valid_i[ST_EXE1] && valid_i[ST_EXE2] &&
                      (ex1_mem_i == MEM_LOAD) && (ex2_mem_i == MEM_STORE);

    // oldest originating stage first
    always_comb begin
        if (port_hit)      cause = CAUSE_PORT;
        else if (jump_hit) cause = CAUSE_JUMP;
        else if (raw_hit)  cause = CAUSE_RAW;
        else               cause = CAUSE_NONE;
    end

    always_comb begin
        unique case (cause)
            CAUSE_PORT: begin
                flush_o          = MASK_TO_EXE1;
                redirect_valid_o = 1'b1;
                redirect_pc_o    = pc_ex1_i;
            end
            CAUSE_JUMP: begin
                flush_o          = MASK_FRONT;
                redirect_valid_o = 1'b1;
                redirect_pc_o    = pc_ex1_i + ex1_jump_off_i;
            end
            CAUSE_RAW: begin
                flush_o          = MASK_FRONT;
                redirect_valid_o = 1'b1;
                redirect_pc_o    = pc_rr_i;
            end
            default: begin
                flush_o          = '0;
                redirect_valid_o = 1'b0;
                redirect_pc_o    = '0;
            end
        endcase
    end

    always_comb begin
        // R3: any flush always clears the three front stages
        p_front_cleared_r3: assert (flush_o == '0 || flush_o[2:0] == 3'b111);
        // R8: restart is offered exactly when something is flushed
        p_redirect_pairs_r8: assert (redirect_valid_o == (flush_o != '0));
    end

endmodule

// File: rtl/pipe_flush_ctrl.sv
module pipe_flush_ctrl
    import pipe_flush_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned XLEN  = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  fetch_req_i,
    output logic [NUM_STAGES-1:0] stage_valid_o,
    input  logic [REG_W-1:0]      rs1_idx_i,
    input  logic                  rs1_used_i,
    input  logic [REG_W-1:0]      rs2_idx_i,
    input  logic                  rs2_used_i,
    input  logic [XLEN-1:0]       pc_rr_i,
    input  logic [REG_W-1:0]      ex1_rd_i,
    input  logic                  ex1_wen_i,
    input  logic [1:0]            ex1_mem_i,
    input  logic                  ex1_jump_i,
    input  logic [XLEN-1:0]       ex1_jump_off_i,
    input  logic [XLEN-1:0]       pc_ex1_i,
    input  logic [REG_W-1:0]      ex2_rd_i,
    input  logic                  ex2_wen_i,
    input  logic [1:0]            ex2_mem_i,
    input  logic [REG_W-1:0]      wb_rd_i,
    input  logic                  wb_wen_i,
    output logic [NUM_STAGES-1:0] flush_o,
    output logic                  redirect_valid_o,
    output logic [XLEN-1:0]       redirect_pc_o
);

    localparam int unsigned NREG = 1 << REG_W;

    logic [NUM_STAGES-1:0] valid;
    logic [NUM_STAGES-1:0] flush;
    logic [NREG-1:0]       pending;
    logic [REG_W-1:0]      prod_rd [NUM_PROD];

    assign prod_rd[0] = ex1_rd_i;
    assign prod_rd[1] = ex2_rd_i;
    assign prod_rd[2] = wb_rd_i;

    pipe_valid_chain #(.N(NUM_STAGES)) u_chain (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fetch_req_i (fetch_req_i),
        .flush_i     (flush),
        .valid_o     (valid)
    );

    pipe_scoreboard #(.REG_W(REG_W)) u_board (
        .prod_valid_i (valid[ST_WBACK:ST_EXE1]),
        .prod_wen_i   ({wb_wen_i, ex2_wen_i, ex1_wen_i}),
        .prod_rd_i    (prod_rd),
        .pending_o    (pending)
    );

    pipe_hazard_arbiter #(.REG_W(REG_W), .XLEN(XLEN)) u_arb (
        .valid_i          (valid),
        .pending_i        (pending),
        .rs1_idx_i        (rs1_idx_i),
        .rs1_used_i       (rs1_used_i),
        .rs2_idx_i        (rs2_idx_i),
        .rs2_used_i       (rs2_used_i),
        .pc_rr_i          (pc_rr_i),
        .ex1_jump_i       (ex1_jump_i),
        .ex1_jump_off_i   (ex1_jump_off_i),
        .pc_ex1_i         (pc_ex1_i),
        .ex1_mem_i        (ex1_mem_i),
        .ex2_mem_i        (ex2_mem_i),
        .flush_o          (flush),
        .redirect_valid_o (redirect_valid_o),
        .redirect_pc_o    (redirect_pc_o)
    );

    assign stage_valid_o = valid;
    assign flush_o       = flush;

    // R6: with register read and execute 1 both empty nothing can flush
    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid[ST_REGRD] && !valid[ST_EXE1]) |-> (flush == '0));

    // R5: a load behind a store always reaches back into execute 1
    p_port_reach_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid[ST_EXE1] && valid[ST_EXE2] && ex1_mem_i == MEM_LOAD &&
         ex2_mem_i == MEM_STORE) |-> (flush[ST_EXE1] && redirect_pc_o == pc_ex1_i));

    // R2: a write-back-only producer to register 0 never blocks a read of 0
    p_zero_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid[ST_REGRD] && !valid[ST_EXE1] && !valid[ST_EXE2] &&
         rs1_used_i && !rs2_used_i && rs1_idx_i == '0) |-> (flush == '0));

endmodule

// File: tb/pipe_flush_ctrl_test.sv
module pipe_flush_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 3;
    localparam int XW = 16;
    localparam int N_PAT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [5:0]    stage_valid;
    logic [RW-1:0] rs1 = '0, rs2 = '0;
    logic          use1 = 1'b0, use2 = 1'b0;
    logic [XW-1:0] pc_rr = '0, pc_ex1 = '0, joff = '0;
    logic [RW-1:0] rd1 = '0, rd2 = '0, rd3 = '0;
    logic          wen1 = 1'b0, wen2 = 1'b0, wen3 = 1'b0;
    logic [1:0]    mem1 = '0, mem2 = '0;
    logic          jump = 1'b0;
    logic [5:0]    flush;
    logic          rvalid;
    logic [XW-1:0] rpc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_flush_ctrl #(.REG_W(RW), .XLEN(XW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .fetch_req_i(fetch_req),
        .stage_valid_o(stage_valid),
        .rs1_idx_i(rs1), .rs1_used_i(use1), .rs2_idx_i(rs2), .rs2_used_i(use2),
        .pc_rr_i(pc_rr),
        .ex1_rd_i(rd1), .ex1_wen_i(wen1), .ex1_mem_i(mem1), .ex1_jump_i(jump),
        .ex1_jump_off_i(joff), .pc_ex1_i(pc_ex1),
        .ex2_rd_i(rd2), .ex2_wen_i(wen2), .ex2_mem_i(mem2),
        .wb_rd_i(rd3), .wb_wen_i(wen3),
        .flush_o(flush), .redirect_valid_o(rvalid), .redirect_pc_o(rpc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input logic [31:0] x);
        logic [31:0] h;
        h = x * 32'h9E3779B1;
        h = h ^ (h >> 15);
        h = h * 32'h85EBCA6B;
        h = h ^ (h >> 13);
        return h;
    endfunction

    // pending register set from the requirement text (R2)
    function automatic logic [7:0] pend_of(input logic [5:0] v, input bit use_valid);
        logic [7:0] p;
        p = '0;
        for (int r = 1; r < 8; r++) begin
            if ((!use_valid || v[3]) && wen1 && rd1 == RW'(r)) p[r] = 1'b1;
            if ((!use_valid || v[4]) && wen2 && rd2 == RW'(r)) p[r] = 1'b1;
            if ((!use_valid || v[5]) && wen3 && rd3 == RW'(r)) p[r] = 1'b1;
        end
        return p;
    endfunction

    initial begin
        logic [5:0]    mv;
        logic [5:0]    ef;
        logic [XW-1:0] epc;
        logic [7:0]    pend, pend_nv;
        logic [31:0]   h;
        bit            raw, jmp, port, raw_nv, jmp_nv, port_nv, zero_probe;
        string         tag;

        mv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        check("R1 reset valid", 32'(stage_valid), 32'h0);
        check("R8 reset flush", 32'(flush), 32'h0);
        check("R8 reset redirect", 32'(rvalid), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < N_PAT; i++) begin
            @(negedge clk);
            // R1: valid chain after the previous edge
            check("R1 valid chain", 32'(stage_valid), 32'(mv));

            h    = mix(32'(i));
            rs1  = h[2:0];
            rs2  = h[5:3];
            use1 = h[6];
            use2 = h[7];
            rd1  = h[10:8];
            rd2  = h[13:11];
            rd3  = h[16:14];
            wen1 = h[17];
            wen2 = h[18];
            wen3 = h[19];
            mem1 = h[21:20];
            mem2 = h[23:22];
            jump = (h[26:24] == 3'd0);
            fetch_req = (h[28:27] != 2'd0);
            joff   = mix(32'(i) + 32'd77)[XW-1:0];
            pc_rr  = XW'(i * 4);
            pc_ex1 = XW'(i * 12 + 40);
            #1;

            pend    = pend_of(mv, 1'b1);
            pend_nv = pend_of(6'h3F, 1'b0);
            raw  = mv[2] && ((use1 && pend[rs1]) || (use2 && pend[rs2]));
            jmp  = mv[3] && jump;
            port = mv[3] && mv[4] && mem1 == 2'b01 && mem2 == 2'b10;
            raw_nv  = (use1 && pend_nv[rs1]) || (use2 && pend_nv[rs2]);
            jmp_nv  = jump;
            port_nv = mem1 == 2'b01 && mem2 == 2'b10;
            zero_probe = mv[2] && ((use1 && rs1 == 0) || (use2 && rs2 == 0)) &&
                         ((mv[3] && wen1 && rd1 == 0) || (mv[4] && wen2 && rd2 == 0) ||
                          (mv[5] && wen3 && rd3 == 0));

            if (port)      begin ef = 6'b001111; epc = pc_ex1; end
            else if (jmp)  begin ef = 6'b000111; epc = pc_ex1 + joff; end
            else if (raw)  begin ef = 6'b000111; epc = pc_rr; end
            else           begin ef = 6'b000000; epc = '0; end

            if (int'(port) + int'(jmp) + int'(raw) > 1) tag = "R7 priority";
            else if (port)                              tag = "R5 port conflict";
            else if (jmp)                               tag = "R4 jump";
            else if (raw)                               tag = "R3 raw";
            else if (raw_nv || jmp_nv || port_nv)       tag = "R6 invalid ignored";
            else if (zero_probe)                        tag = "R2 x0 never pending";
            else                                        tag = "R8 no hazard";

            check($sformatf("%s flush i=%0d", tag, i), 32'(flush), 32'(ef));
            check($sformatf("%s redirect_valid i=%0d", tag, i), 32'(rvalid), 32'(ef != 0));
            check($sformatf("%s redirect_pc i=%0d", tag, i), 32'(rpc), 32'(epc));

            mv = {mv[4:0] & ~ef[4:0], fetch_req};
            @(posedge clk);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (N_PAT + 200) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule